// File: doc/BRIEF.md
# Circular Physical Register Free List

This block keeps the pool of physical register tags that no architected register currently owns. It is a ring with separate read and write pointers. The rename stage takes tags from the head, up to four per cycle. The commit stage returns released tags at the tail, also up to four per cycle. Because the two pointers move on their own, taking tags and returning tags in the same cycle never conflict.

After reset the ring holds every tag above the architected range, in ascending order. The first `NUM_ARCH` tags are assumed to hold the initial architected mappings. A rename request for k tags is granted all at once or not at all. When the ring alone is too short, the `BYPASS` parameter picks the behaviour. With bypass off, the request stalls. With bypass on, tags being returned in that same cycle are offered straight to the renamer after the stored ones.

Top module: `phys_tag_freelist`

## Requirements
- R1: After reset, `avail_cnt` equals NUM_PHYS-NUM_ARCH (24 by default), and lane i of `alloc_tags` (bits i*TAGW upward) shows tag NUM_ARCH+i.
- R2: Lane i of `alloc_tags` shows the i-th oldest tag in the pool. A granted request of k tags removes exactly the k oldest, so the next tag moves to lane 0 on the following cycle.
- R3: Returned tags on lanes 0..`free_num`-1 join the pool behind all tags already in it, in lane order. They are later handed out in that order.
- R4: Each cycle `avail_cnt` becomes its old value, plus `free_num`, minus `alloc_num` when the request is granted.
- R5: A request with `alloc_num` from 1 to 4 is granted (`alloc_grant`=1, `alloc_stall`=0) only when enough tags are available. Otherwise `alloc_stall`=1, `alloc_grant`=0 and no tag leaves the pool, while returned tags are still accepted that cycle.
- R6: With BYPASS=1, enough means `avail_cnt`+`free_num` is at least the request. Lanes from `avail_cnt` upward then show the tags being returned that cycle, in lane order. With BYPASS=0 only `avail_cnt` counts.
- R7: `alloc_num`=0 gives `alloc_grant`=0 and `alloc_stall`=0 and leaves the head of the pool unchanged.
- R8: Both pointers wrap modulo the pool depth, so FIFO order holds across the wrap point.
- R9: The stored count never exceeds the pool depth, and `alloc_num` and `free_num` never exceed 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; reloads the pool |
| alloc_num | input | 3 | Number of tags the rename stage wants this cycle (0..4) |
| alloc_tags | output | 20 | Four candidate tags, lane 0 in the low bits |
| alloc_grant | output | 1 | Request satisfied; the first alloc_num lanes are taken |
| alloc_stall | output | 1 | Request refused this cycle for lack of tags |
| free_num | input | 3 | Number of tags returned by commit this cycle (0..4) |
| free_tags | input | 20 | Returned tags, lane 0 in the low bits |
| avail_cnt | output | 5 | Tags currently stored in the pool |

## Verification
If a pointer is off by one or wraps at the wrong place, the wrong tag value shows on `alloc_tags` at once. With a bad wrap it shows the first time the head crosses the end of the ring. A count error appears on `avail_cnt` in the cycle after the faulty update. It also shows as a wrong grant or stall decision once the pool runs near empty. A broken bypass path only shows when a request exceeds the stored count, so the stimulus drains the pool completely and then asks for tags in the same cycle that others are returned.

// File: rtl/phys_tag_freelist.sv
module phys_tag_freelist #(
  parameter int NUM_PHYS = 32,
  parameter int NUM_ARCH = 8,
  parameter int LANES    = 4,
  parameter bit BYPASS   = 1'b1,
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int TAGW  = $clog2(NUM_PHYS),
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LW-1:0]         alloc_num,
  output logic [LANES*TAGW-1:0] alloc_tags,
  output logic                  alloc_grant,
  output logic                  alloc_stall,
  input  logic [LW-1:0]         free_num,
  input  logic [LANES*TAGW-1:0] free_tags,
  output logic [CW-1:0]         avail_cnt
);

  logic [TAGW-1:0] pool [DEPTH];
  logic [PW-1:0]   head, tail;
  logic [CW-1:0]   count;
  logic            enough;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= DEPTH) s = s - DEPTH;
    return s[PW-1:0];
  endfunction

  assign enough      = int'(alloc_num) <= int'(count) + (BYPASS ? int'(free_num) : 0);
  assign alloc_grant = (alloc_num != '0) && enough;
  assign alloc_stall = (alloc_num != '0) && !enough;
  assign avail_cnt   = count;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      int k;
      k = g - int'(count);
      alloc_tags[g*TAGW +: TAGW] = pool[step(head, g)];
      if (BYPASS && k >= 0 && k < int'(free_num))
        alloc_tags[g*TAGW +: TAGW] = free_tags[k*TAGW +: TAGW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pool[i] <= TAGW'(NUM_ARCH + i);
      head  <= '0;
      tail  <= '0;
      count <= CW'(DEPTH);
    end else begin
      for (int j = 0; j < LANES; j++)
        if (j < int'(free_num)) pool[step(tail, j)] <= free_tags[j*TAGW +: TAGW];
      tail  <= step(tail, int'(free_num));
      head  <= alloc_grant ? step(head, int'(alloc_num)) : head;
      count <= CW'(int'(count) + int'(free_num) - (alloc_grant ? int'(alloc_num) : 0));
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  a_r9_lane_limit: assert property (@(posedge clk) disable iff (!rst_n)
    int'(alloc_num) <= LANES && int'(free_num) <= LANES);
  a_r8_ring_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    int'(head) < DEPTH && int'(tail) < DEPTH &&
    (int'(count) == DEPTH ? tail == head : tail == step(head, int'(count))));
  a_r5_stall_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |=> $stable(head));
  a_r5_grant_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_grant && alloc_stall));
  a_r7_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_num == '0) |-> (!alloc_grant && !alloc_stall));
  a_r7_zero_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_num == '0) |=> $stable(head));
  a_r6_bypass_covered: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_grant && int'(alloc_num) > int'(count)) |->
      (BYPASS && int'(free_num) >= int'(alloc_num) - int'(count)));

endmodule

// File: tb/phys_tag_freelist_bench.sv
`timescale 1ns/1ps
module phys_tag_freelist_bench;
  localparam int TAGW = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  alloc_num = '0;
  logic [19:0] alloc_tags;
  logic        alloc_grant, alloc_stall;
  logic [2:0]  free_num = '0;
  logic [19:0] free_tags = '0;
  logic [4:0]  avail_cnt;

  int checks = 0;
  int fails  = 0;
  int q[$];

  always #2.5 clk = ~clk;

  phys_tag_freelist u_phys_tag_freelist (
    .clk(clk), .rst_n(rst_n), .alloc_num(alloc_num), .alloc_tags(alloc_tags),
    .alloc_grant(alloc_grant), .alloc_stall(alloc_stall), .free_num(free_num),
    .free_tags(free_tags), .avail_cnt(avail_cnt));

  // {req, nfree, f0, f1, f2, f3, grant, avail_after}
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {3'd4, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd20},
    {3'd3, 3'd2, 5'd8,  5'd9,  5'd0,  5'd0,  1'b1, 5'd19},
    {3'd0, 3'd1, 5'd10, 5'd0,  5'd0,  5'd0,  1'b0, 5'd20},
    {3'd4, 3'd4, 5'd11, 5'd12, 5'd13, 5'd14, 1'b1, 5'd20},
    {3'd4, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd16},
    {3'd4, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd12},
    {3'd4, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd8},
    {3'd4, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd4},
    {3'd4, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd0},
    {3'd1, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b0, 5'd0},
    {3'd2, 3'd3, 5'd15, 5'd16, 5'd17, 5'd0,  1'b1, 5'd1},
    {3'd3, 3'd1, 5'd18, 5'd0,  5'd0,  5'd0,  1'b0, 5'd2},
    {3'd2, 3'd0, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 5'd0},
    {3'd0, 3'd4, 5'd19, 5'd20, 5'd21, 5'd22, 1'b0, 5'd4},
    {3'd4, 3'd4, 5'd23, 5'd24, 5'd25, 5'd26, 1'b1, 5'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset_state();
    check(avail_cnt == 5'd24, "R1 avail", avail_cnt, 24);
    check(!alloc_grant && !alloc_stall, "R1 R7 idle", {alloc_grant, alloc_stall}, 0);
    for (int i = 0; i < 4; i++)
      check(int'(alloc_tags[i*TAGW +: TAGW]) == 8 + i, "R1 tag", alloc_tags[i*TAGW +: TAGW], 8 + i);
  endtask

  task automatic reset_model();
    q.delete();
    for (int i = 8; i < 32; i++) q.push_back(i);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    reset_model();
    @(negedge clk);
    check_reset_state();

    for (int v = 0; v < NV; v++) begin
      logic [2:0] rq, nf;
      logic eg;
      logic [4:0] ea;
      int lst[$];
      bit gexp;
      @(negedge clk);
      rq = VEC[v][31:29];
      nf = VEC[v][28:26];
      eg = VEC[v][5];
      ea = VEC[v][4:0];
      alloc_num = rq;
      free_num  = nf;
      free_tags = {VEC[v][10:6], VEC[v][15:11], VEC[v][20:16], VEC[v][25:21]};
      #1;
      lst = q;
      for (int j = 0; j < int'(nf); j++) lst.push_back(int'(free_tags[j*TAGW +: TAGW]));
      gexp = (rq != 0) && (int'(rq) <= lst.size());
      check(alloc_grant == gexp && alloc_grant == eg, "R5 R6 R7 grant", alloc_grant, eg);
      check(alloc_stall == ((rq != 0) && !gexp), "R5 stall", alloc_stall, (rq != 0) && !gexp);
      for (int i = 0; i < 4 && i < lst.size(); i++)
        check(int'(alloc_tags[i*TAGW +: TAGW]) == lst[i], "R2 R3 R6 R8 tag",
              alloc_tags[i*TAGW +: TAGW], lst[i]);
      @(posedge clk);
      #1;
      for (int j = 0; j < int'(nf); j++) q.push_back(int'(free_tags[j*TAGW +: TAGW]));
      if (gexp) for (int j = 0; j < int'(rq); j++) void'(q.pop_front());
      check(avail_cnt == ea && int'(avail_cnt) == q.size(), "R4 R9 avail", avail_cnt, ea);
    end

    @(negedge clk);
    alloc_num = '0;
    free_num  = '0;
    #1;
    check(int'(alloc_tags[0 +: TAGW]) == q[0], "R7 R8 head after run", alloc_tags[0 +: TAGW], q[0]);

    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    reset_model();
    @(negedge clk);
    check_reset_state();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule